// File: doc/BRIEF.md
# Write-Only I2C Target for a Table of 10-Bit Codes

This block is a write-only I2C target. It fills a table of 24 ten-bit codes that sits next to it. A bus master addresses the target and sends a one-byte register pointer. It then sends one or more data words of two bytes each. For each completed word, the block issues a single-cycle write strobe with a 5-bit register index and the 10-bit code. The register file that receives the strobe holds the actual storage.

SCL and SDA are sampled by a faster system clock through two-flop synchronisers. START and STOP are recognised as SDA edges while SCL is high. The block acknowledges by asserting a pull-low request for SDA during the ninth clock of every byte it accepts. The seven-bit target address is 111010 followed by a strap bit, so the write byte is E8h when the strap is 0 and EAh when it is 1. The pointer advances once per two-byte word. This allows a whole table to be loaded in one transaction.

Top module: `i2c_code_writer`

## Requirements
- R1: An address byte equal to {111010, addr_sel_i, 0} is acknowledged: sda_pull_o is 1 while SCL is high in the ninth clock.
- R2: An address byte that does not match, or that has the R/W bit (bit 0) set to 1, gets no acknowledge. No later byte is acknowledged and no write strobe occurs until the next START.
- R3: Bits 4:0 of the pointer byte select the first register index. Bits 7:5 are ignored.
- R4: A data word is a high byte then a low byte, each MSB first. Code bits 9:8 are bits 1:0 of the high byte and bits 7:0 are the low byte. The upper six bits of the high byte are ignored.
- R5: A register is written only at the end of a word's low byte. A word cut short by STOP after its high byte causes no write.
- R6: In a transaction with several words, each further word goes to the next index (pointer plus 1 per word) until STOP.
- R7: Every byte accepted after a matching address (pointer, high byte, low byte) is acknowledged in its ninth clock.
- R8: Pointer increment wraps inside the 5-bit field, so index 31 is followed by index 0.
- R9: Words aimed at indices 24 to 31 are acknowledged but produce no write strobe.
- R10: A repeated START discards any partial word and makes the next byte an address byte.
- R11: After reset, sda_pull_o and wr_en_o are 0.
- R12: Each completed word produces exactly one wr_en_o pulse, one system-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| addr_sel_i | input | 1 | Strap for the lowest address bit |
| sda_pull_o | output | 1 | 1 requests SDA to be pulled low (acknowledge) |
| wr_en_o | output | 1 | Single-cycle write strobe to the register file |
| wr_idx_o | output | 5 | Register index of the write |
| wr_data_o | output | 10 | Code value of the write |

## Verification
The commit of a word and the start of that word's acknowledge happen on the same system-clock edge, the first one after SCL falls at the end of the low byte. The pointer increment, and its wrap from 31 to 0, is registered on that same edge. The bench provokes this with a single write of 32 words that starts at index 20 and crosses both the 24-register boundary and the 5-bit wrap. It judges the result by checking that every low byte is still acknowledged, that indices 24 to 31 leave no strobe, and that the words after the wrap land at indices 0 onward with their arithmetically computed values. A checker also requires the strobe and the acknowledge request to be high together.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_HI,
    PH_LO
  } phase_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2cw_cond_det.sv
module i2cw_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // bus conditions: SDA moving while SCL stays high
  assign start_o = scl_q & scl_s_i & sda_q & ~sda_s_i;
  assign stop_o  = scl_q & scl_s_i & ~sda_q & sda_s_i;
  assign rise_o  = ~scl_q & scl_s_i;
  assign fall_o  = scl_q & ~scl_s_i;
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int          IDX_W    = 5,
  parameter int          DATA_W   = 10,
  parameter int          NUM_REGS = 24,
  parameter logic [5:0]  ADDR_HI  = 6'b111010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              pull_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int               HI_W  = DATA_W - BYTE_W;
  localparam logic [IDX_W:0]   LIMIT = NUM_REGS[IDX_W:0];
  localparam logic [3:0]       LAST_BIT = 4'd8;
  localparam logic [3:0]       ACK_SLOT = 4'd9;

  phase_t              phase;
  logic [3:0]          cnt;
  logic [BYTE_W-1:0]   shreg;
  logic [IDX_W-1:0]    ptr;
  logic [HI_W-1:0]     hi_q;
  logic                addr_ok;

  assign addr_ok = (shreg == {ADDR_HI, strap_i, 1'b0});

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      ptr       <= '0;
      hi_q      <= '0;
      pull_o    <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else if (start_i) begin
      phase  <= PH_ADDR;
      cnt    <= '0;
      pull_o <= 1'b0;
    end else if (stop_i) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      pull_o <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (rise_i && cnt < LAST_BIT) begin
        shreg <= {shreg[BYTE_W-2:0], sda_i};
        cnt   <= cnt + 4'd1;
      end else if (fall_i && cnt == LAST_BIT) begin
        cnt    <= ACK_SLOT;
        pull_o <= 1'b1;
        case (phase)
          PH_ADDR: begin
            if (addr_ok) begin
              phase <= PH_PTR;
            end else begin
              phase  <= PH_IDLE;
              pull_o <= 1'b0;
              cnt    <= '0;
            end
          end
          PH_PTR: begin
            ptr   <= shreg[IDX_W-1:0];
            phase <= PH_HI;
          end
          PH_HI: begin
            hi_q  <= shreg[HI_W-1:0];
            phase <= PH_LO;
          end
          PH_LO: begin
            wr_en_o   <= ({1'b0, ptr} < LIMIT);
            wr_idx_o  <= ptr;
            wr_data_o <= {hi_q, shreg};
            ptr       <= ptr + 1'b1;
            phase     <= PH_HI;
          end
          default: ;
        endcase
      end else if (fall_i && cnt == ACK_SLOT) begin
        cnt    <= '0;
        pull_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_code_writer.sv
module i2c_code_writer #(
  parameter int         IDX_W    = 5,
  parameter int         DATA_W   = 10,
  parameter int         NUM_REGS = 24,
  parameter int         SYNC_N   = 2,
  parameter logic [5:0] ADDR_HI  = 6'b111010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [1:0] bus_s;
  logic start_w, stop_w, rise_w, fall_w;

  i2cw_sync #(.WIDTH(2), .STAGES(SYNC_N)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (bus_s)
  );

  i2cw_cond_det cond_i (
    .clk     (clk),
    .rst     (rst),
    .scl_s_i (bus_s[1]),
    .sda_s_i (bus_s[0]),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  i2cw_engine #(
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_HI  (ADDR_HI)
  ) eng_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .sda_i     (bus_s[0]),
    .strap_i   (addr_sel_i),
    .pull_o    (sda_pull_o),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int IDX_W    = 5,
  parameter int NUM_REGS = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_pull_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_pull_o && !wr_en_o)); // R11

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o); // R12

  AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (int'(wr_idx_o) < NUM_REGS)); // R9

  AST_COMMIT_ACKED: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> sda_pull_o); // R7

  AST_ACK_NOT_DROPPED_WITH_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en_o) |-> $rose(sda_pull_o)); // R5
endmodule

bind i2c_code_writer i2cw_checker #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sda_pull_o (sda_pull_o),
  .wr_en_o    (wr_en_o),
  .wr_idx_o   (wr_idx_o)
);

// File: tb/i2c_code_writer_tb_top.sv
`timescale 1ns/1ps
module i2c_code_writer_tb_top;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_line;
  logic sda_pull_o, wr_en_o;
  logic [4:0] wr_idx_o;
  logic [9:0] wr_data_o;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;

  i2c_code_writer dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .addr_sel_i (strap),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [9:0] obs [32];
  int nwr = 0;
  int run = 0;
  int maxrun = 0;
  logic [9:0] expm [32];
  int expn = 0;

  initial for (int i = 0; i < 32; i++) obs[i] = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en_o) begin
        obs[wr_idx_o] = wr_data_o;
        nwr++;
        run++;
        if (run > maxrun) maxrun = run;
      end else begin
        run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_clk(4);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic i2c_stop();
    wait_clk(4);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(4);
      sda_m = b[i];
      wait_clk(H - 4);
      scl_m = 1'b1;
      wait_clk(H);
      scl_m = 1'b0;
    end
    wait_clk(4);
    sda_m = 1'b1;
    wait_clk(H - 4);
    scl_m = 1'b1;
    wait_clk(H / 2);
    @(negedge clk);
    ack = sda_pull_o;
    wait_clk(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic wr_seq(input logic [7:0] a, input logic [7:0] p, input int n,
                        input int base, input int step);
    bit ok, ack;
    logic [9:0] d;
    logic [4:0] ix;
    ok = (a == {6'b111010, strap, 1'b0});
    i2c_start();
    send_byte(a, ack);
    if (ok) chk(ack == ok, "R1 address ack", ack, ok);
    else    chk(ack == ok, "R2 address nack", ack, ok);
    send_byte(p, ack);
    chk(ack == ok, "R7 pointer ack", ack, ok);
    for (int k = 0; k < n; k++) begin
      d = 10'(base + k * step);
      send_byte({6'(k * 13 + 5), d[9:8]}, ack);
      chk(ack == ok, "R7 high byte ack", ack, ok);
      send_byte(d[7:0], ack);
      chk(ack == ok, "R7 low byte ack", ack, ok);
      if (ok) begin
        ix = 5'(int'(p[4:0]) + k);
        if (ix < 5'd24) begin
          expm[ix] = d;
          expn++;
        end
      end
    end
    i2c_stop();
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < 24; i++)
      chk(obs[i] == expm[i], req, obs[i], expm[i]);
    chk(nwr == expn, {req, " strobe count"}, nwr, expn);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 32; i++) expm[i] = '0;
    wait_clk(6);
    @(negedge clk);
    chk(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R11 reset outputs", {sda_pull_o, wr_en_o}, 0);
    rst = 1'b0;
    wait_clk(10);
    chk(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R11 idle outputs", {sda_pull_o, wr_en_o}, 0);

    // R3 R4: single-word sweep of every index under both strap values, junk in ignored bits
    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      for (int ix = 0; ix < 32; ix++) begin
        wr_seq({6'b111010, strap, 1'b0}, {3'(ix * 5 + s), 5'(ix)}, 1,
               (ix * 37 + s * 301) & 1023, 0);
      end
      compare_all("R3 R4 single sweep");
    end

    // R9: indices with no register never reach the outputs
    for (int i = 24; i < 32; i++) chk(obs[i] == 10'd0, "R9 unbacked index", obs[i], 0);

    // R2: wrong strap, read bit, foreign address
    strap = 1'b1;
    wr_seq(8'hE8, 8'h02, 2, 10'h155, 1);
    wr_seq(8'hEB, 8'h02, 2, 10'h2AA, 1);
    wr_seq(8'h50, 8'h02, 2, 10'h0F0, 1);
    compare_all("R2 ignored transaction");
    strap = 1'b0;
    wr_seq(8'hEA, 8'h04, 1, 10'h111, 0);
    compare_all("R2 strap mismatch");

    // R5: high byte then STOP
    i2c_start();
    send_byte(8'hE8, ack);
    send_byte(8'h02, ack);
    send_byte(8'h03, ack);
    chk(ack == 1'b1, "R7 high byte ack", ack, 1);
    i2c_stop();
    compare_all("R5 half word");

    // R6 R8 R9: long run crossing the table end and the 5-bit wrap
    wr_seq(8'hE8, 8'h14, 32, 10'h3F0, 29);
    compare_all("R6 R8 multi word wrap");

    // R10: repeated START in the middle of a word
    i2c_start();
    send_byte(8'hE8, ack);
    send_byte(8'h03, ack);
    send_byte(8'h02, ack);
    i2c_start();
    send_byte(8'hE8, ack);
    chk(ack == 1'b1, "R10 address after repeated start", ack, 1);
    send_byte(8'h05, ack);
    send_byte(8'hFD, ack);
    send_byte(8'h5A, ack);
    i2c_stop();
    expm[5] = 10'h15A;
    expn++;
    compare_all("R10 repeated start");
    chk(obs[3] == expm[3], "R10 partial word dropped", obs[3], expm[3]);

    chk(maxrun == 1, "R12 strobe width", maxrun, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule